// File: doc/BRIEF.md
# MSI Snooping Line State Controller

This block keeps the coherence state of every line of one private cache in a bus-based multiprocessor that uses the three-state MSI protocol. Two kinds of event act on the per-line state array. The local processor issues read or write requests. The snooping logic presents reads and exclusive reads that other caches place on the shared bus. For a processor request, the block decides whether it can complete locally or needs a bus transaction. If it needs one, the block raises a request toward a bus arbiter and names the transaction. It signals completion to the processor once the access is allowed. For a snooped transaction, it updates the line and, when the line held dirty data, asks for that data to be written back.

All outputs are combinational functions of the current inputs and the registered state array. A processor request is held stable by the requester until `cpu_hit` is seen high. A snoop is presented for exactly one cycle. The data array, the arbiter itself and memory sit outside the block.

Top module: `msi_line_ctrl`

## Requirements
- R1: Each line is Invalid (2'b00), Shared (2'b01) or Modified (2'b10); the code 2'b11 never occurs, and reset leaves every line Invalid with `bus_req`, `cpu_hit` and `flush` low.
- R2: A processor read of an Invalid line raises `bus_req` with `bus_cmd` = 0 (bus read) and `bus_idx` equal to the request index, and leaves the line Shared.
- R3: A processor write of an Invalid or Shared line raises `bus_req` with `bus_cmd` = 1 (exclusive bus read) and leaves the line Modified.
- R4: A processor read of a Shared or Modified line, and a processor write of a Modified line, assert `cpu_hit` in the request cycle with `bus_req` low and leave the state unchanged.
- R5: A snooped bus read (`snoop_excl` = 0) of a Modified line asserts `flush` with `flush_idx` equal to the snooped index and leaves the line Shared.
- R6: A snooped exclusive read (`snoop_excl` = 1) leaves a Modified or Shared line Invalid; `flush` is asserted only when the line was Modified.
- R7: A snooped bus read of a Shared line, and any snoop of an Invalid line, leave the state unchanged and do not assert `flush`.
- R8: When a snoop and a processor request address the same line in one cycle, the snoop's transition is applied first and the processor request is judged against the resulting state.
- R9: While a request needs the bus, `cpu_hit` stays low until `bus_gnt` is high; the line state changes on the clock edge that ends the grant cycle.
- R10: `flush` is high only in a cycle with `snoop_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present; held until `cpu_hit` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_idx | input | IDX_W | Line index of the processor request |
| cpu_hit | output | 1 | Processor access may complete this cycle |
| snoop_valid | input | 1 | Snooped transaction present (one cycle) |
| snoop_excl | input | 1 | 1 = exclusive bus read, 0 = bus read |
| snoop_idx | input | IDX_W | Line index of the snooped transaction |
| flush | output | 1 | Write back the dirty line at `flush_idx` |
| flush_idx | output | IDX_W | Line to write back |
| bus_req | output | 1 | Request for the bus toward the arbiter |
| bus_cmd | output | 1 | Transaction to issue: 0 = bus read, 1 = exclusive bus read |
| bus_idx | output | IDX_W | Line index of the transaction |
| bus_gnt | input | 1 | Arbiter grant |

## Verification
The assertions check on every cycle that no line holds the unused code, that a committed processor update is the state found in the array on the next cycle, and that a stalled request never reports a hit. They also check that the bus command matches the request type, that flushes occur only alongside snoops, and that a same-cycle exclusive snoop forces a colliding read onto the bus. Whether each transition leaves the line in the right state can be seen only through the bench's sequences. In those sequences, a later access or snoop to the same line shows the state through the bus request it causes or the flush it produces. The same holds for the order of snoop and request on one line, and for the length of a stall under a delayed grant.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_SHR = 2'b01,
        ST_MOD = 2'b10
    } line_st_e;

    typedef enum logic {
        BUS_RD  = 1'b0,
        BUS_RDX = 1'b1
    } bus_op_e;

endpackage

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
(
    input  logic     snp_valid,
    input  logic     snp_excl,
    input  line_st_e cur_st,
    output line_st_e nxt_st,
    output logic     do_flush
);

    always_comb begin
        nxt_st   = cur_st;
        do_flush = 1'b0;
        if (snp_valid) begin
            unique case (cur_st)
                ST_MOD: begin
                    do_flush = 1'b1;
                    nxt_st   = snp_excl ? ST_INV : ST_SHR;
                end
                ST_SHR: begin
                    if (snp_excl) nxt_st = ST_INV;
                end
                default: nxt_st = cur_st;
            endcase
        end
    end

endmodule

// File: rtl/msi_cpu_unit.sv
module msi_cpu_unit
    import msi_pkg::*;
(
    input  logic     req_valid,
    input  logic     req_write,
    input  line_st_e cur_st,
    input  logic     gnt,
    output logic     need_bus,
    output bus_op_e  op,
    output logic     hit,
    output line_st_e nxt_st
);

    logic miss;

    always_comb begin
        miss     = req_write ? (cur_st != ST_MOD) : (cur_st == ST_INV);
        need_bus = req_valid && miss;
        op       = req_write ? BUS_RDX : BUS_RD;
        hit      = req_valid && (!miss || gnt);
        nxt_st   = cur_st;
        if (hit) begin
            if (req_write)             nxt_st = ST_MOD;
            else if (cur_st == ST_INV) nxt_st = ST_SHR;
        end
    end

endmodule

// File: rtl/msi_state_array.sv
module msi_state_array
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_idx,
    input  line_st_e         snp_st,
    input  logic             cpu_we,
    input  logic [IDX_W-1:0] cpu_idx,
    input  line_st_e         cpu_st,
    output line_st_e         snp_rd_st,
    output line_st_e         cpu_rd_st
);

    typedef struct packed {
        line_st_e [NUM_LINES-1:0] st;
    } arr_t;

    arr_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        if (snp_we) arr_d.st[snp_idx] = snp_st;
        if (cpu_we) arr_d.st[cpu_idx] = cpu_st;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) arr_q.st[i] <= ST_INV;
        end else begin
            arr_q <= arr_d;
        end
    end

    assign snp_rd_st = arr_q.st[snp_idx];
    assign cpu_rd_st = arr_q.st[cpu_idx];

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_legal
            p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
                arr_q.st[g] != 2'b11);
        end
    endgenerate

    // R9: the processor-side update is what the array holds next cycle
    p_cpu_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |=> arr_q.st[$past(cpu_idx)] == $past(cpu_st));

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req_valid,
    input  logic             cpu_req_write,
    input  logic [IDX_W-1:0] cpu_req_idx,
    output logic             cpu_hit,
    input  logic             snoop_valid,
    input  logic             snoop_excl,
    input  logic [IDX_W-1:0] snoop_idx,
    output logic             flush,
    output logic [IDX_W-1:0] flush_idx,
    output logic             bus_req,
    output logic             bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    input  logic             bus_gnt
);

    line_st_e snp_cur_st, snp_nxt_st;
    line_st_e arr_cpu_st, cpu_cur_st, cpu_nxt_st;
    logic     same_line;
    logic     snp_flush;
    logic     cpu_need_bus, cpu_hit_w;
    bus_op_e  cpu_op;

    msi_state_array #(
        .NUM_LINES(NUM_LINES),
        .IDX_W    (IDX_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .snp_we   (snoop_valid),
        .snp_idx  (snoop_idx),
        .snp_st   (snp_nxt_st),
        .cpu_we   (cpu_hit_w),
        .cpu_idx  (cpu_req_idx),
        .cpu_st   (cpu_nxt_st),
        .snp_rd_st(snp_cur_st),
        .cpu_rd_st(arr_cpu_st)
    );

    msi_snoop_unit u_snoop (
        .snp_valid(snoop_valid),
        .snp_excl (snoop_excl),
        .cur_st   (snp_cur_st),
        .nxt_st   (snp_nxt_st),
        .do_flush (snp_flush)
    );

    // snoop has precedence on a shared line: processor sees post-snoop state
    assign same_line  = snoop_valid && (snoop_idx == cpu_req_idx);
    assign cpu_cur_st = same_line ? snp_nxt_st : arr_cpu_st;

    msi_cpu_unit u_cpu (
        .req_valid(cpu_req_valid),
        .req_write(cpu_req_write),
        .cur_st   (cpu_cur_st),
        .gnt      (bus_gnt),
        .need_bus (cpu_need_bus),
        .op       (cpu_op),
        .hit      (cpu_hit_w),
        .nxt_st   (cpu_nxt_st)
    );

    assign cpu_hit   = cpu_hit_w;
    assign bus_req   = cpu_need_bus;
    assign bus_cmd   = logic'(cpu_op);
    assign bus_idx   = cpu_req_idx;
    assign flush     = snp_flush;
    assign flush_idx = snoop_idx;

    p_flush_on_snoop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> snoop_valid);

    p_stall_no_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |-> !cpu_hit);

    p_req_from_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> cpu_req_valid);

    p_read_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !cpu_req_write) |-> (bus_cmd == 1'b0));

    p_write_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && cpu_req_write) |-> (bus_cmd == 1'b1));

    p_excl_snoop_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && snoop_excl && cpu_req_valid && !cpu_req_write &&
         snoop_idx == cpu_req_idx) |-> bus_req);

endmodule

// File: tb/tb_msi_line_ctrl.sv
module tb_msi_line_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_LINES  = 16;
    localparam int IDX_W      = $clog2(NUM_LINES);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cpu_req_valid = 1'b0;
    logic             cpu_req_write = 1'b0;
    logic [IDX_W-1:0] cpu_req_idx = '0;
    logic             cpu_hit;
    logic             snoop_valid = 1'b0;
    logic             snoop_excl = 1'b0;
    logic [IDX_W-1:0] snoop_idx = '0;
    logic             flush;
    logic [IDX_W-1:0] flush_idx;
    logic             bus_req;
    logic             bus_cmd;
    logic [IDX_W-1:0] bus_idx;
    logic             bus_gnt = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        string tag;
        bit    bus;
        bit    cmd;
        int    idx;
    } cpu_item_t;

    typedef struct {
        string tag;
        bit    fl;
        int    idx;
    } snp_item_t;

    cpu_item_t cpu_q[$];
    snp_item_t snp_q[$];
    cpu_item_t mc;
    snp_item_t ms;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_line_ctrl #(.NUM_LINES(NUM_LINES)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req_valid(cpu_req_valid),
        .cpu_req_write(cpu_req_write),
        .cpu_req_idx  (cpu_req_idx),
        .cpu_hit      (cpu_hit),
        .snoop_valid  (snoop_valid),
        .snoop_excl   (snoop_excl),
        .snoop_idx    (snoop_idx),
        .flush        (flush),
        .flush_idx    (flush_idx),
        .bus_req      (bus_req),
        .bus_cmd      (bus_cmd),
        .bus_idx      (bus_idx),
        .bus_gnt      (bus_gnt)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (cpu_hit) begin
                if (cpu_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected cpu_hit", 1, 0);
                end else begin
                    mc = cpu_q.pop_front();
                    check(bus_req == mc.bus, mc.tag, "bus_req at hit", int'(bus_req), int'(mc.bus));
                    if (mc.bus) begin
                        check(bus_cmd == mc.cmd, mc.tag, "bus_cmd", int'(bus_cmd), int'(mc.cmd));
                        check(int'(bus_idx) == mc.idx, mc.tag, "bus_idx", int'(bus_idx), mc.idx);
                    end
                end
            end
            if (snoop_valid) begin
                if (snp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected snoop", 1, 0);
                end else begin
                    ms = snp_q.pop_front();
                    check(flush == ms.fl, ms.tag, "flush", int'(flush), int'(ms.fl));
                    if (ms.fl)
                        check(int'(flush_idx) == ms.idx, ms.tag, "flush_idx", int'(flush_idx), ms.idx);
                end
            end else if (flush) begin
                check(1'b0, "R10", "flush without snoop", 1, 0);
            end
        end
    end

    task automatic cpu_access(input bit wr, input int idx, input bit exp_bus,
                              input int gnt_delay, input string tag);
        int waited = 0;
        bit done = 0;
        cpu_q.push_back('{tag: tag, bus: exp_bus, cmd: wr, idx: idx});
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_idx   = IDX_W'(idx);
        bus_gnt       = (gnt_delay == 0);
        while (!done) begin
            @(negedge clk);
            if (cpu_hit) done = 1;
            else check(bus_req == 1'b1, "R9", "stall without bus_req", int'(bus_req), 1);
            @(posedge clk); #1;
            waited++;
            if (waited >= gnt_delay) bus_gnt = 1'b1;
        end
        cpu_req_valid = 1'b0;
        bus_gnt       = 1'b0;
    endtask

    task automatic snoop(input bit excl, input int idx, input bit exp_fl, input string tag);
        snp_q.push_back('{tag: tag, fl: exp_fl, idx: idx});
        snoop_valid = 1'b1;
        snoop_excl  = excl;
        snoop_idx   = IDX_W'(idx);
        @(posedge clk); #1;
        snoop_valid = 1'b0;
    endtask

    task automatic collide(input bit excl, input bit exp_fl, input bit wr,
                           input int idx, input bit exp_bus, input string tag);
        snp_q.push_back('{tag: tag, fl: exp_fl, idx: idx});
        cpu_q.push_back('{tag: tag, bus: exp_bus, cmd: wr, idx: idx});
        snoop_valid   = 1'b1;
        snoop_excl    = excl;
        snoop_idx     = IDX_W'(idx);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_idx   = IDX_W'(idx);
        bus_gnt       = 1'b1;
        @(posedge clk); #1;
        snoop_valid   = 1'b0;
        cpu_req_valid = 1'b0;
        bus_gnt       = 1'b0;
    endtask

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the outputs
        check(bus_req == 1'b0, "R1", "bus_req after reset", int'(bus_req), 0);
        check(cpu_hit == 1'b0, "R1", "cpu_hit after reset", int'(cpu_hit), 0);
        check(flush == 1'b0, "R1", "flush after reset", int'(flush), 0);
        @(posedge clk); #1;

        // R1: lines start Invalid, so reads and writes need the bus
        cpu_access(0, 3, 1, 0, "R1");
        cpu_access(1, 15, 1, 0, "R1");

        // R2 with a delayed grant (R9), then R4 local read in Shared
        cpu_access(0, 0, 1, 3, "R2");
        cpu_access(0, 0, 0, 0, "R4");
        // R3 from Shared, then local hits in Modified
        cpu_access(1, 0, 1, 1, "R3");
        cpu_access(1, 0, 0, 0, "R4");
        cpu_access(0, 0, 0, 0, "R4");

        // R5: snooped read of Modified -> flush, Shared
        snoop(0, 0, 1, "R5");
        cpu_access(0, 0, 0, 0, "R5");
        cpu_access(1, 0, 1, 2, "R5");

        // R6: exclusive snoop of Modified -> flush, Invalid
        snoop(1, 0, 1, "R6");
        cpu_access(0, 0, 1, 0, "R6");
        // R6: exclusive snoop of Shared -> Invalid, no flush
        snoop(1, 0, 0, "R6");
        cpu_access(0, 0, 1, 0, "R6");

        // R7: snooped read of Shared keeps Shared
        snoop(0, 0, 0, "R7");
        cpu_access(0, 0, 0, 0, "R7");
        cpu_access(1, 0, 1, 0, "R7");
        // R7: snoops of an Invalid line
        snoop(0, 5, 0, "R7");
        snoop(1, 5, 0, "R7");
        cpu_access(0, 5, 1, 0, "R7");

        // R3 from Invalid on line 7, confirmed by a flushing snoop
        cpu_access(1, 7, 1, 2, "R3");
        snoop(0, 7, 1, "R3");

        // R8: line 7 Shared; exclusive snoop + read same cycle -> bus read
        collide(1, 0, 0, 7, 1, "R8");
        cpu_access(0, 7, 0, 0, "R8");
        // R8: Shared; exclusive snoop + write -> exclusive read, then Modified
        collide(1, 0, 1, 7, 1, "R8");
        // R8: Modified; snooped read + local read -> flush, local hit
        collide(0, 1, 0, 7, 0, "R8");
        cpu_access(1, 7, 1, 0, "R8");
        snoop(1, 7, 1, "R8");

        // R9: long grant delay, state committed at grant
        cpu_access(1, 9, 1, 6, "R9");
        cpu_access(1, 9, 0, 0, "R9");

        repeat (2) @(posedge clk);
        check(cpu_q.size() == 0, "R4", "pending cpu items", cpu_q.size(), 0);
        check(snp_q.size() == 0, "R10", "pending snoop items", snp_q.size(), 0);
        summary();
    end

endmodule